// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter of parameterised width (four bits by default). It can be preset from a parallel bus and cleared at any moment by an asynchronous reset. Two active-high enables gate counting. The first, `cnt_en`, is shared by every stage of a chain and stalls all of them together. The second, `chain_en`, also gates the terminal-count flag `term_out`.

Wider counters are built by wiring each stage's `term_out` to the next stage's `chain_en` and sharing `cnt_en`, clock, reset, load and preset lines. `term_out` is combinational and depends only on the local count and `chain_en`. The carry therefore passes through the stages within one clock period, and every stage still changes on the same clock edge. There is no data stream, so all pins are plain control and status signals with no handshake.

The next count is formed with per-bit look-ahead. Each bit toggles when all bits below it are ones, so no carry ripples from bit to bit inside a stage.

Top module: `casc_bin_counter`

## Requirements
- R1: While `arst_n` is low, `count` is all zeros, and it goes to zero as soon as `arst_n` falls, without waiting for a clock edge.
- R2: While `arst_n` is low, a rising clock edge with `load_n` low or with both enables high leaves `count` at zero.
- R3: On a rising edge with `arst_n` high and `load_n` low, `count` takes the value of `preset`, whatever the enables are.
- R4: On a rising edge with `arst_n` high, `load_n` high and both `cnt_en` and `chain_en` high, `count` increases by one.
- R5: On a rising edge with `arst_n` and `load_n` high and either enable low, `count` keeps its value.
- R6: An increment from the all-ones value gives all zeros.
- R7: `term_out` is high exactly when `chain_en` is high and `count` is all ones. It follows those inputs without a clock edge and does not depend on `cnt_en` or `load_n`.
- R8: After `arst_n` rises, the first following rising edge already loads or counts.
- R9: A chain of stages, each with its `chain_en` fed from the previous stage's `term_out` (the first from the shared `cnt_en`), counts as one wide binary counter across every carry boundary. This includes the wrap from all ones to zero, holds driven by `cnt_en`, and loads of a wide value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loads and increments happen on its rising edge |
| arst_n | input | 1 | Asynchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low; takes priority over counting |
| preset | input | WIDTH | Value loaded when `load_n` is low |
| cnt_en | input | 1 | Count enable shared across a chain; does not gate `term_out` |
| chain_en | input | 1 | Count enable that also gates `term_out`; driven by the previous stage's `term_out` in a chain |
| count | output | WIDTH | Current count |
| term_out | output | 1 | Terminal-count flag: `chain_en` AND count all ones |

## Verification
A corrupted count register shows at `count` at the sampling point right after the edge that stored it. It then stays wrong on every later hold or increment until the next load or reset. A faulty look-ahead term for bit i appears on the first increment from a value whose low i bits are all ones. Wrong gating of `term_out` shows combinationally, within the same cycle, as soon as the count reaches all ones while `chain_en` or `cnt_en` changes. In the chained bench the same flaw also shows one edge later as a wrong upper-stage value at a carry boundary.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  // Operation chosen for the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output ctr_op_e op
);
  // Load wins over counting; counting needs both enables
  always_comb begin
    if (!load_n)                 op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_INC;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_lookahead.sv
module ctr_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_inc,
  output logic             all_ones
);
  // Each bit flips when every lower bit is one: no bit-to-bit ripple
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign q_inc[0] = ~q[0];
    end else begin : g_upper
      assign q_inc[i] = q[i] ^ (&q[i-1:0]);
    end
  end

  assign all_ones = &q;
endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] preset,
  input  logic [WIDTH-1:0] q_inc,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD: q <= preset;
        OP_INC:  q <= q_inc;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] count,
  output logic             term_out
);
  ctr_op_e          op;
  logic [WIDTH-1:0] q_inc;
  logic             all_ones;

  ctr_op_decode u_dec (
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  ctr_lookahead #(.WIDTH(WIDTH)) u_la (
    .q        (count),
    .q_inc    (q_inc),
    .all_ones (all_ones)
  );

  ctr_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .arst_n (arst_n),
    .op     (op),
    .preset (preset),
    .q_inc  (q_inc),
    .q      (count)
  );

  // Terminal count ignores cnt_en so the carry can pass a stalled chain
  assign term_out = chain_en & all_ones;
endmodule

// File: rtl/casc_bin_counter_chk.sv
module casc_bin_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             arst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] count,
  input logic             term_out
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  AST_RESET_CLEARS: assert property (@(posedge clk) !arst_n |-> count == '0); // R2

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!arst_n)
    !load_n |=> count == $past(preset)); // R3

  AST_INCREMENT: assert property (@(posedge clk) disable iff (!arst_n)
    (load_n && cnt_en && chain_en) |=> count == $past(count) + ONE); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(count)); // R5

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (term_out && cnt_en && load_n) |=> count == '0); // R6

  AST_TERM_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!arst_n)
    term_out |-> chain_en); // R7
endmodule

bind casc_bin_counter casc_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .load_n   (load_n),
  .preset   (preset),
  .cnt_en   (cnt_en),
  .chain_en (chain_en),
  .count    (count),
  .term_out (term_out)
);

// File: tb/tb_casc_bin_counter.sv
module tb_casc_bin_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 4;
  localparam int STAGES = 3;
  localparam int CW     = W * STAGES;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          arst_n;
  logic          load_n, cnt_en, chain_en;
  logic [W-1:0]  preset;
  logic [W-1:0]  count;
  logic          term_out;

  logic              c_load_n, c_run;
  logic [CW-1:0]     c_preset, c_count;
  logic [STAGES-1:0] c_term;
  logic [STAGES:0]   c_link;

  int nvec = 0;
  int nerr = 0;
  logic done = 1'b0;

  casc_bin_counter #(.WIDTH(W)) dut (
    .clk(clk), .arst_n(arst_n), .load_n(load_n), .preset(preset),
    .cnt_en(cnt_en), .chain_en(chain_en), .count(count), .term_out(term_out)
  );

  assign c_link[0] = c_run;
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    casc_bin_counter #(.WIDTH(W)) u_st (
      .clk(clk), .arst_n(arst_n), .load_n(c_load_n), .preset(c_preset[g*W +: W]),
      .cnt_en(c_run), .chain_en(c_link[g]), .count(c_count[g*W +: W]),
      .term_out(c_term[g])
    );
    assign c_link[g+1] = c_term[g];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model_next(logic [W-1:0] q, logic l, logic e1,
                                              logic e2, logic [W-1:0] p);
    if (!l) return p;
    if (e1 && e2) return q + W'(1);
    return q;
  endfunction

  function automatic logic model_term(logic [W-1:0] q, logic e2);
    return e2 && (q == {W{1'b1}});
  endfunction

  logic [W-1:0]  q_m;
  logic [CW-1:0] cq_m;

  task automatic step(input logic l, input logic e1, input logic e2, input logic [W-1:0] p);
    logic [W-1:0] exp;
    string tag;
    @(negedge clk);
    load_n = l; cnt_en = e1; chain_en = e2; preset = p;
    #1;
    check("R7", 32'(term_out), 32'(model_term(q_m, e2)));
    exp = model_next(q_m, l, e1, e2, p);
    if (!l) tag = "R3";
    else if (e1 && e2) tag = (q_m == {W{1'b1}}) ? "R6" : "R4";
    else tag = "R5";
    @(posedge clk); #1;
    check(tag, 32'(count), 32'(exp));
    q_m = exp;
  endtask

  task automatic chain_step(input logic l, input logic run, input logic [CW-1:0] p);
    logic [CW-1:0] exp;
    @(negedge clk);
    c_load_n = l; c_run = run; c_preset = p;
    #1;
    check("R9", 32'(c_term[STAGES-1]), 32'(run && (cq_m == {CW{1'b1}})));
    exp = !l ? p : (run ? cq_m + CW'(1) : cq_m);
    @(posedge clk); #1;
    check("R9", 32'(c_count), 32'(exp));
    cq_m = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    arst_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; preset = '0;
    c_load_n = 1'b1; c_run = 1'b0; c_preset = '0;
    q_m = '0; cq_m = '0;

    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    check("R1", 32'(count), 32'h0);
    check("R7", 32'(term_out), 32'h0);

    // R2: load and count ignored while reset is held
    @(negedge clk);
    load_n = 1'b0; preset = 4'hA;
    @(posedge clk); #1;
    check("R2", 32'(count), 32'h0);
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    @(posedge clk); #1;
    check("R2", 32'(count), 32'h0);

    // R8: first edge after release counts
    @(negedge clk);
    arst_n = 1'b1;
    @(posedge clk); #1;
    check("R8", 32'(count), 32'h1);
    q_m = 4'h1;

    // R3 with enables low, then R4 up to all ones
    step(1'b0, 1'b0, 1'b0, 4'hE);
    step(1'b1, 1'b1, 1'b1, 4'h3);
    // R7: flag high at all ones with cnt_en low; R5 hold
    step(1'b1, 1'b0, 1'b1, 4'h0);
    // R7: flag low when chain_en low; R5 hold
    step(1'b1, 1'b1, 1'b0, 4'h0);
    // R6: wrap
    step(1'b1, 1'b1, 1'b1, 4'h0);
    check("R6", 32'(count), 32'h0);
    // R3: load beats counting
    step(1'b0, 1'b1, 1'b1, 4'h5);

    // R1: asynchronous clear between edges
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    #2 arst_n = 1'b0;
    #1;
    check("R1", 32'(count), 32'h0);
    @(negedge clk);
    arst_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    @(posedge clk); #1;
    check("R8", 32'(count), 32'h1);
    q_m = 4'h1;

    // Random mix for R3, R4, R5, R6, R7
    for (int i = 0; i < 600; i++) begin
      logic l, e1, e2;
      l  = ($urandom % 8) != 0;
      e1 = ($urandom % 4) != 0;
      e2 = ($urandom % 4) != 0;
      step(l, e1, e2, W'($urandom));
    end

    // R9: chained counter through carry boundaries
    cnt_en = 1'b0; chain_en = 1'b0; load_n = 1'b1;
    chain_step(1'b0, 1'b0, 12'h0FA);
    for (int i = 0; i < 300; i++) chain_step(1'b1, 1'b1, '0);
    for (int i = 0; i < 400; i++) chain_step(1'b1, ($urandom % 4) != 0, '0);
    chain_step(1'b0, 1'b1, 12'hEFD);
    for (int i = 0; i < 8; i++) chain_step(1'b1, 1'b1, '0);
    chain_step(1'b0, 1'b0, 12'hFFC);
    for (int i = 0; i < 8; i++) chain_step(1'b1, (i % 3) != 1, '0);
    check("R9", 32'(c_count < 12'h010), 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule